// File: doc/BRIEF.md
# Phase-Coherent FSK Tone Synthesizer

The block turns a fixed master clock into a square-wave frequency-shift-keyed tone. It divides the clock with a programmable half-period counter. The half-period length comes from a table indexed by a 3-bit mode and by the current transmit bit: a 1 gives the mark tone and a 0 gives the space tone. A new length is loaded only when the running half-period ends. A change of data or mode therefore never shortens or restarts a half-period, and the tone stays phase-continuous across a mark/space transition.

A second divider, driven by the same master clock, produces a baud-reference square wave. Its frequency is sixteen times the highest bit rate that the mode uses, for either direction. The mode also selects this divider's half-period, and a new value likewise takes effect only at a half-period boundary. The three tables are synthesis-time parameters. The defaults assume a 4.4336 MHz master clock and cover 75, 150, 600 and 1200 baud.

Top module: `fsk_synth`

## Requirements
- R1: While `rst_i` is high at a clock edge, both `tone_o` and `baud_clk_o` are 0 after that edge. At the first edge with `rst_i` low, both outputs go to 1.
- R2: With `tx_data_i` = 1 when a tone half-period starts, that half-period lasts MARK_HALF[m] clock cycles, where m = {std_sel_i, rate_sel_i[1], rate_sel_i[0]}. The defaults for m = 0..7 are 1705, 1705, 5684, 5684, 1847, 1847, 1746, 5684.
- R3: With `tx_data_i` = 0 when a tone half-period starts, that half-period lasts SPACE_HALF[m] cycles. The defaults for m = 0..7 are 1056, 1056, 4926, 4926, 1008, 1008, 2072, 4926.
- R4: A change of `tx_data_i` inside a tone half-period does not alter the length of that half-period. The new length applies from the next half-period.
- R5: A change of the mode inputs inside a half-period does not alter the length of that half-period, for the tone or for the baud reference.
- R6: Each baud-reference half-period lasts BAUD_HALF[m] cycles, where m is sampled when the half-period starts. The defaults for m = 0..7 are 115, 231, 115, 115, 115, 231, 924, 1847, which equal the master clock divided by 32 times the highest bit rate.
- R7: Both outputs toggle only at the end of a half-period and are otherwise stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| std_sel_i | input | 1 | Standard select, mode index bit 2 |
| rate_sel_i | input | 2 | Rate select, mode index bits 1:0 |
| tx_data_i | input | 1 | Transmit bit, 1 = mark, 0 = space |
| tone_o | output | 1 | FSK square-wave tone |
| baud_clk_o | output | 1 | Baud-reference clock, 16x highest rate |

## Verification
Every mode is held at a steady mark and then at a steady space. For each combination, one full tone half-period and one baud half-period are timed. This catches a wrong table entry, a swapped mark/space choice and mis-ordered mode bits. Data is then flipped, and separately the mode is switched, in the middle of a half-period. The measured length must equal the old value, which separates a design that reloads at the boundary from one that reloads immediately. A behavioural model runs alongside and checks both outputs on every cycle, so an off-by-one in the reload is caught as well.

// File: rtl/fsk_synth.sv
module fsk_synth #(
  parameter int CW = 16,
  parameter logic [8*CW-1:0] MARK_HALF  = {16'd5684, 16'd1746, 16'd1847, 16'd1847,
                                           16'd5684, 16'd5684, 16'd1705, 16'd1705},
  parameter logic [8*CW-1:0] SPACE_HALF = {16'd4926, 16'd2072, 16'd1008, 16'd1008,
                                           16'd4926, 16'd4926, 16'd1056, 16'd1056},
  parameter logic [8*CW-1:0] BAUD_HALF  = {16'd1847, 16'd924, 16'd231, 16'd115,
                                           16'd115, 16'd115, 16'd231, 16'd115}
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       std_sel_i,
  input  logic [1:0] rate_sel_i,
  input  logic       tx_data_i,
  output logic       tone_o,
  output logic       baud_clk_o
);

  logic [2:0]    mode;
  logic [CW-1:0] tone_len, baud_len;
  logic [CW-1:0] tcnt, bcnt;

  assign mode     = {std_sel_i, rate_sel_i};
  assign tone_len = tx_data_i ? MARK_HALF[mode*CW +: CW] : SPACE_HALF[mode*CW +: CW];
  assign baud_len = BAUD_HALF[mode*CW +: CW];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tcnt   <= '0;
      tone_o <= 1'b0;
    end else if (tcnt == '0) begin
      tcnt   <= tone_len - 1'b1;
      tone_o <= ~tone_o;
    end else begin
      tcnt   <= tcnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bcnt       <= '0;
      baud_clk_o <= 1'b0;
    end else if (bcnt == '0) begin
      bcnt       <= baud_len - 1'b1;
      baud_clk_o <= ~baud_clk_o;
    end else begin
      bcnt       <= bcnt - 1'b1;
    end
  end

  a_r1_reset_low: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!tone_o && !baud_clk_o));

  a_r7_tone_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (tcnt != '0) |=> $stable(tone_o));

  a_r7_baud_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (bcnt != '0) |=> $stable(baud_clk_o));

  a_r2_tone_toggle: assert property (@(posedge clk_i) disable iff (rst_i)
    (tcnt == '0) |=> (tone_o != $past(tone_o)));

  a_r4_no_midreload: assert property (@(posedge clk_i) disable iff (rst_i)
    (tcnt != '0) |=> (tcnt == $past(tcnt) - 1'b1));

  a_r5_baud_no_midreload: assert property (@(posedge clk_i) disable iff (rst_i)
    (bcnt != '0) |=> (bcnt == $past(bcnt) - 1'b1));

endmodule

// File: tb/sim_fsk_synth.sv
module sim_fsk_synth;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic std_sel = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic tx_data = 1'b1;
  logic tone, bclk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  fsk_synth u0 (
    .clk_i(clk), .rst_i(rst), .std_sel_i(std_sel), .rate_sel_i(rate_sel),
    .tx_data_i(tx_data), .tone_o(tone), .baud_clk_o(bclk)
  );

  function automatic int exp_mark(int m);
    int t[8] = '{1705, 1705, 5684, 5684, 1847, 1847, 1746, 5684};
    return t[m];
  endfunction
  function automatic int exp_space(int m);
    int t[8] = '{1056, 1056, 4926, 4926, 1008, 1008, 2072, 4926};
    return t[m];
  endfunction
  function automatic int exp_baud(int m);
    int t[8] = '{115, 231, 115, 115, 115, 231, 924, 1847};
    return t[m];
  endfunction

  // Behavioural model: cycles remaining in each half-period
  int  m_tleft = 0, m_bleft = 0;
  bit  m_tone = 0, m_bclk = 0;

  always @(posedge clk) begin
    int md;
    md = {std_sel, rate_sel};
    cycles++;
    if (rst) begin
      m_tleft = 0; m_bleft = 0; m_tone = 0; m_bclk = 0;
    end else begin
      if (m_tleft <= 1) begin
        m_tone  = !m_tone;
        m_tleft = tx_data ? exp_mark(md) : exp_space(md);
      end else m_tleft--;
      if (m_bleft <= 1) begin
        m_bclk  = !m_bclk;
        m_bleft = exp_baud(md);
      end else m_bleft--;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (tone !== m_tone || bclk !== m_bclk) begin
      errors++;
      $display("FAIL R7 R4 R5 cycle model at %0d: tone/baud=%b%b expected %b%b",
               cycles, tone, bclk, m_tone, m_bclk);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tone_edge();
    logic p;
    p = tone;
    do @(negedge clk); while (tone == p);
  endtask

  task automatic wait_baud_edge();
    logic p;
    p = bclk;
    do @(negedge clk); while (bclk == p);
  endtask

  task automatic time_tone(output int n);
    logic p;
    p = tone; n = 0;
    do begin @(negedge clk); n++; end while (tone == p);
  endtask

  task automatic time_baud(output int n);
    logic p;
    p = bclk; n = 0;
    do begin @(negedge clk); n++; end while (bclk == p);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 tone in reset", tone, 0);
    check("R1 baud in reset", bclk, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tone first edge", tone, 1);
    check("R1 baud first edge", bclk, 1);

    for (int m = 0; m < 8; m++) begin
      for (int d = 1; d >= 0; d--) begin
        @(negedge clk);
        {std_sel, rate_sel} = m[2:0];
        tx_data = d[0];
        wait_tone_edge();
        time_tone(n);
        if (d == 1) check($sformatf("R2 mark mode %0d", m), n, exp_mark(m));
        else        check($sformatf("R3 space mode %0d", m), n, exp_space(m));
      end
      wait_baud_edge();
      time_baud(n);
      check($sformatf("R6 baud mode %0d", m), n, exp_baud(m));
    end

    // R4: flip data mid half-period
    @(negedge clk);
    {std_sel, rate_sel} = 3'd0; tx_data = 1'b1;
    wait_tone_edge();
    wait_tone_edge();
    repeat (100) @(negedge clk);
    tx_data = 1'b0;
    time_tone(n);
    check("R4 data change mid half", n + 100, exp_mark(0));
    time_tone(n);
    check("R4 new data next half", n, exp_space(0));

    // R5: change mode mid half-period (tone and baud)
    tx_data = 1'b1;
    {std_sel, rate_sel} = 3'd4;
    wait_tone_edge();
    wait_tone_edge();
    repeat (50) @(negedge clk);
    {std_sel, rate_sel} = 3'd2;
    time_tone(n);
    check("R5 mode change mid tone half", n + 50, exp_mark(4));
    time_tone(n);
    check("R5 new mode next tone half", n, exp_mark(2));

    {std_sel, rate_sel} = 3'd7;
    wait_baud_edge();
    wait_baud_edge();
    repeat (20) @(negedge clk);
    {std_sel, rate_sel} = 3'd1;
    time_baud(n);
    check("R5 mode change mid baud half", n + 20, exp_baud(7));
    time_baud(n);
    check("R6 new mode next baud half", n, exp_baud(1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule